// File: doc/BRIEF.md
# Bit-Band Alias Remapper

This block sits between a processor load/store port and a word-addressed memory or peripheral bus. Two 32 MB alias windows let software address one bit of a 1 MB region per alias word. A read in a window fetches the target word and returns only the chosen bit in bit 0. A write in a window runs a locked read-modify-write that replaces that single bit and leaves every other bit as it was.

All other addresses reach the downstream bus unchanged, through a combinational path with no added cycle. An alias access holds the upstream ready low until its final downstream phase completes. A misaligned alias address is refused with an error response and is never remapped.

Top module: `bitbandRemap`

## Requirements
- R1: An address whose bits [31:25] match 0x22000000 or 0x42000000 is an alias access (windows 0x22000000–0x23FFFFFF and 0x42000000–0x43FFFFFF). Any other address, including 0x21FFFFFC, 0x24000000 and 0x41FFFFFC, passes through.
- R2: An alias address A in window k targets the word at regionBase_k + (A[24:7] × 4), with regionBase 0x20000000 or 0x40000000, at bit index A[6:2]. For example 0x22000008 gives bit 2 of 0x20000000, and 0x23FFFFFC gives bit 31 of 0x200FFFFC. The downstream read of an alias access uses that address.
- R3: An alias read returns the selected bit of the target word in upRdata[0], with upRdata[31:1] zero.
- R4: An alias write reads the target word, then writes it back with only the selected bit replaced by upWdata[0]. Bits [31:1] of the write data are ignored. For example, writing 0 at 0x22000008 turns 0x3355AACC into 0x3355AAC8.
- R5: dnLock is high during both the read phase and the write phase of an alias write. It is low for alias reads and pass-through accesses.
- R6: upReady stays low until the last downstream phase of an alias access completes. With w wait cycles per downstream phase, an alias read completes in 2+w cycles and an alias write in 3+2w cycles.
- R7: An alias access with addr[1:0] not 00 completes in its first cycle with upError=1 and upReady=1. It issues no downstream request and leaves memory unchanged.
- R8: An alias access of byte (size 0) or halfword (size 1) behaves as a word alias access. Its downstream phases use size 2 (word).
- R9: Outside the alias windows, the downstream request, write flag, address, size (0 byte, 1 halfword, 2 word) and write data equal the upstream values. upReady equals dnReady, upRdata equals dnRdata and upError is 0, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | Upstream request, held until upReady |
| upWrite | input | 1 | Upstream write (1) or read (0) |
| upAddr | input | 32 | Upstream byte address |
| upSize | input | 2 | Upstream size: 0 byte, 1 halfword, 2 word |
| upWdata | input | 32 | Upstream write data |
| upRdata | output | 32 | Upstream read data |
| upReady | output | 1 | Upstream transfer completes this cycle |
| upError | output | 1 | Error response (misaligned alias access) |
| dnReq | output | 1 | Downstream request |
| dnWrite | output | 1 | Downstream write flag |
| dnAddr | output | 32 | Downstream byte address |
| dnSize | output | 2 | Downstream size |
| dnWdata | output | 32 | Downstream write data |
| dnRdata | input | 32 | Downstream read data |
| dnReady | input | 1 | Downstream phase completes this cycle |
| dnLock | output | 1 | Lock held across the read-modify-write |

## Verification
The hardest case to reach is a downstream wait inside an alias write. Here the lock must hold and upReady must stay low across a stalled read phase and then a stalled write phase. The bench memory model inserts a programmable number of wait cycles, changed from access to access. This places completion at every position in the sequence. The bench checks the cycle count, the lock seen in each phase and the resulting word against a shadow copy.

// File: rtl/bbPkg.sv
`timescale 1ns/1ps
package bbPkg;
  localparam int DATA_W = 32;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} bbState_e;

  typedef struct packed {
    logic passThru;
    logic capture;
    logic issueRd;
    logic issueWr;
    logic keepWord;
    logic respond;
    logic lockOn;
    logic flagErr;
  } bbStrobe_t;
endpackage

// File: rtl/bbAddrMap.sv
`timescale 1ns/1ps
module bbAddrMap #(
  parameter logic [31:0] REGION0 = 32'h2000_0000,
  parameter logic [31:0] REGION1 = 32'h4000_0000,
  parameter logic [31:0] ALIAS0  = 32'h2200_0000,
  parameter logic [31:0] ALIAS1  = 32'h4200_0000,
  parameter int ALIAS_BITS = 25
) (
  input  logic [31:0] addr,
  output logic        aliasHit,
  output logic        misaligned,
  output logic [31:0] target,
  output logic [bbPkg::BIT_W-1:0] bitIdx
);
  import bbPkg::*;
  localparam int IDX_LO  = 2;
  localparam int WORD_LO = IDX_LO + BIT_W;
  localparam int OFF_W   = ALIAS_BITS - WORD_LO + 2;
  localparam logic [31:0] REGIONS [2] = '{REGION0, REGION1};
  localparam logic [31:0] ALIASES [2] = '{ALIAS0, ALIAS1};

  logic [1:0] hitVec;
  logic [31:0] tgtVec [2];
  logic [OFF_W-1:0] wordOff;

  assign wordOff = {addr[ALIAS_BITS-1:WORD_LO], 2'b00};

  for (genvar g = 0; g < 2; g++) begin : g_win
    assign hitVec[g] = (addr[31:ALIAS_BITS] == ALIASES[g][31:ALIAS_BITS]);
    assign tgtVec[g] = REGIONS[g] | {{(32-OFF_W){1'b0}}, wordOff};
  end

  assign aliasHit   = |hitVec;
  assign misaligned = (addr[1:0] != 2'b00);
  assign target     = hitVec[1] ? tgtVec[1] : tgtVec[0];
  assign bitIdx     = addr[WORD_LO-1:IDX_LO];
endmodule

// File: rtl/bbCtrl.sv
`timescale 1ns/1ps
module bbCtrl (
  input  logic clk,
  input  logic rstN,
  input  logic upReq,
  input  logic upWrite,
  input  logic aliasHit,
  input  logic misaligned,
  input  logic dnReady,
  output bbPkg::bbStrobe_t strobe,
  output logic upReady,
  output logic busy
);
  import bbPkg::*;
  bbState_e state, nextState;
  logic isWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isWr  <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.capture) isWr <= upWrite;
    end
  end

  always_comb begin
    strobe    = '0;
    upReady   = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (!aliasHit) begin
          strobe.passThru = 1'b1;
          upReady = upReq && dnReady;
        end else if (upReq && misaligned) begin
          strobe.flagErr = 1'b1;
          upReady = 1'b1;
        end else if (upReq) begin
          strobe.capture = 1'b1;
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        strobe.issueRd = 1'b1;
        strobe.lockOn  = isWr;
        if (dnReady) begin
          if (isWr) begin
            strobe.keepWord = 1'b1;
            nextState = ST_WRITE;
          end else begin
            strobe.respond = 1'b1;
            upReady = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        strobe.issueWr = 1'b1;
        strobe.lockOn  = 1'b1;
        if (dnReady) begin
          strobe.respond = 1'b1;
          upReady = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R6: a write phase is only entered from a completed read phase
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE && $past(state) != ST_WRITE) |-> ($past(state) == ST_READ && $past(dnReady)));
endmodule

// File: rtl/bbDatapath.sv
`timescale 1ns/1ps
module bbDatapath (
  input  logic clk,
  input  logic rstN,
  input  bbPkg::bbStrobe_t strobe,
  input  logic        upReq,
  input  logic        upWrite,
  input  logic [31:0] upAddr,
  input  logic [1:0]  upSize,
  input  logic [31:0] upWdata,
  input  logic [31:0] target,
  input  logic [bbPkg::BIT_W-1:0] bitIdx,
  input  logic [31:0] dnRdata,
  output logic        dnReq,
  output logic        dnWrite,
  output logic [31:0] dnAddr,
  output logic [1:0]  dnSize,
  output logic [31:0] dnWdata,
  output logic        dnLock,
  output logic [31:0] upRdata,
  output logic        upError
);
  import bbPkg::*;
  logic [31:0] tgtQ, wordQ;
  logic [BIT_W-1:0] idxQ;
  logic bitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtQ  <= '0;
      wordQ <= '0;
      idxQ  <= '0;
      bitQ  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        tgtQ <= target;
        idxQ <= bitIdx;
        bitQ <= upWdata[0];
      end
      if (strobe.keepWord)
        wordQ <= (dnRdata & ~(32'd1 << idxQ)) | ({31'd0, bitQ} << idxQ);
    end
  end

  always_comb begin
    dnReq = 1'b0; dnWrite = 1'b0; dnAddr = '0; dnSize = '0; dnWdata = '0;
    if (strobe.passThru) begin
      dnReq = upReq; dnWrite = upWrite; dnAddr = upAddr;
      dnSize = upSize; dnWdata = upWdata;
    end else if (strobe.issueRd) begin
      dnReq = 1'b1; dnAddr = tgtQ; dnSize = SIZE_WORD;
    end else if (strobe.issueWr) begin
      dnReq = 1'b1; dnWrite = 1'b1; dnAddr = tgtQ;
      dnSize = SIZE_WORD; dnWdata = wordQ;
    end
  end

  always_comb begin
    upRdata = '0;
    if (strobe.passThru) upRdata = dnRdata;
    else if (strobe.respond && strobe.issueRd) upRdata = {31'd0, dnRdata[idxQ]};
  end

  assign dnLock  = strobe.lockOn;
  assign upError = strobe.flagErr;

  // R4: the written word differs from the word just read in at most one bit
  assert_single_bit_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.keepWord) && strobe.issueWr) |-> ($countones(dnWdata ^ $past(dnRdata)) <= 1));
endmodule

// File: rtl/bitbandRemap.sv
`timescale 1ns/1ps
module bitbandRemap #(
  parameter logic [31:0] REGION0 = 32'h2000_0000,
  parameter logic [31:0] REGION1 = 32'h4000_0000,
  parameter logic [31:0] ALIAS0  = 32'h2200_0000,
  parameter logic [31:0] ALIAS1  = 32'h4200_0000,
  parameter int ALIAS_BITS = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        upReq,
  input  logic        upWrite,
  input  logic [31:0] upAddr,
  input  logic [1:0]  upSize,
  input  logic [31:0] upWdata,
  output logic [31:0] upRdata,
  output logic        upReady,
  output logic        upError,
  output logic        dnReq,
  output logic        dnWrite,
  output logic [31:0] dnAddr,
  output logic [1:0]  dnSize,
  output logic [31:0] dnWdata,
  input  logic [31:0] dnRdata,
  input  logic        dnReady,
  output logic        dnLock
);
  import bbPkg::*;
  bbStrobe_t strobe;
  logic aliasHit, misaligned, busy;
  logic [31:0] target;
  logic [BIT_W-1:0] bitIdx;

  bbAddrMap #(.REGION0(REGION0), .REGION1(REGION1), .ALIAS0(ALIAS0),
              .ALIAS1(ALIAS1), .ALIAS_BITS(ALIAS_BITS)) u_map (
    .addr(upAddr), .aliasHit(aliasHit), .misaligned(misaligned),
    .target(target), .bitIdx(bitIdx));

  bbCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .upReq(upReq), .upWrite(upWrite),
    .aliasHit(aliasHit), .misaligned(misaligned), .dnReady(dnReady),
    .strobe(strobe), .upReady(upReady), .busy(busy));

  bbDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .upReq(upReq), .upWrite(upWrite),
    .upAddr(upAddr), .upSize(upSize), .upWdata(upWdata), .target(target),
    .bitIdx(bitIdx), .dnRdata(dnRdata), .dnReq(dnReq), .dnWrite(dnWrite),
    .dnAddr(dnAddr), .dnSize(dnSize), .dnWdata(dnWdata), .dnLock(dnLock),
    .upRdata(upRdata), .upError(upError));

  // R5: every downstream write produced by an alias access is locked
  assert_lock_on_rmw_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dnReq && dnWrite) |-> dnLock);
  // R6: an alias write only completes upstream together with its downstream write
  assert_ready_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && upReq && upWrite && upReady) |-> (dnReq && dnWrite && dnReady));
  // R7: an error response never issues a downstream request
  assert_error_no_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    upError |-> (upReady && !dnReq));
  // R3: alias read data carries only bit 0
  assert_read_single_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && upReady && !upWrite) |-> (upRdata[31:1] == 31'd0));
  // R8: downstream phases of an alias access are word sized
  assert_alias_word_size_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dnReq) |-> (dnSize == SIZE_WORD));
  // R9: outside the windows the access is forwarded in the same cycle
  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !aliasHit && upReq) |-> (dnReq && dnAddr == upAddr && upReady == dnReady && !dnLock));
endmodule

// File: tb/bitbandRemap_bench.sv
`timescale 1ns/1ps
module bitbandRemap_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upReq = 1'b0, upWrite = 1'b0;
  logic [31:0] upAddr = '0, upWdata = '0;
  logic [1:0] upSize = 2'd2;
  logic [31:0] upRdata, dnAddr, dnWdata, dnRdata;
  logic upReady, upError, dnReq, dnWrite, dnReady, dnLock;
  logic [1:0] dnSize;

  always #4 clk = ~clk;

  bitbandRemap u_bitbandRemap (
    .clk(clk), .rstN(rstN), .upReq(upReq), .upWrite(upWrite), .upAddr(upAddr),
    .upSize(upSize), .upWdata(upWdata), .upRdata(upRdata), .upReady(upReady),
    .upError(upError), .dnReq(dnReq), .dnWrite(dnWrite), .dnAddr(dnAddr),
    .dnSize(dnSize), .dnWdata(dnWdata), .dnRdata(dnRdata), .dnReady(dnReady),
    .dnLock(dnLock));

  // memory model: 16 words indexed by {addr[30], addr[4:2]}
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  int waitSet = 0;
  int waitCnt = 0;
  int txCount = 0;
  logic loadEn = 1'b0;
  logic [3:0] loadIdx = '0;
  logic [31:0] loadVal = '0;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [1:0] rdSize, wrSize;
  logic rdLock, wrLock;

  function automatic logic [3:0] memIdx(input logic [31:0] a);
    return {a[30], a[4:2]};
  endfunction

  assign dnReady = dnReq && (waitCnt == waitSet);
  assign dnRdata = mem[memIdx(dnAddr)];

  always @(posedge clk) begin
    if (loadEn) mem[loadIdx] <= loadVal;
    else if (dnReq) begin
      if (waitCnt == waitSet) begin
        waitCnt <= 0;
        txCount <= txCount + 1;
        if (dnWrite) begin
          mem[memIdx(dnAddr)] <= dnWdata;
          wrAddr <= dnAddr; wrData <= dnWdata; wrSize <= dnSize; wrLock <= dnLock;
        end else begin
          rdAddr <= dnAddr; rdSize <= dnSize; rdLock <= dnLock;
        end
      end else waitCnt <= waitCnt + 1;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadVal = val;
    @(negedge clk);
    loadEn = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [1:0] size,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic err, output int cyc);
    logic r;
    logic done;
    @(negedge clk);
    upReq = 1'b1; upWrite = wr; upAddr = addr; upSize = size; upWdata = wd;
    cyc = 0; done = 1'b0; rd = '0; err = 1'b0;
    while (!done && cyc < 100) begin
      #1;
      r = upReady; rd = upRdata; err = upError;
      cyc++;
      @(posedge clk);
      if (r) done = 1'b1;
      else @(negedge clk);
    end
    #1 upReq = 1'b0;
    if (!done) check("handshake timeout", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] aliasAddr(input int reg_, input int word, input int b);
    logic [31:0] base;
    base = (reg_ == 0) ? 32'h2200_0000 : 32'h4200_0000;
    return base + 32'(word * 128) + 32'(b * 4);
  endfunction

  function automatic logic [31:0] regionAddr(input int reg_, input int word);
    return ((reg_ == 0) ? 32'h2000_0000 : 32'h4000_0000) + 32'(word * 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic err;
    int cyc;
    int tx0;
    logic [31:0] expWord;

    repeat (3) @(posedge clk);
    #1;
    check("R6 reset upReady", {31'd0, upReady}, 32'd0);
    check("R9 reset dnReq", {31'd0, dnReq}, 32'd0);
    check("R5 reset dnLock", {31'd0, dnLock}, 32'd0);
    check("R7 reset upError", {31'd0, upError}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 16; i++) preload(4'(i), 32'h9E37_79B9 * 32'(i + 1) ^ 32'h0F0F_1234);

    // worked example
    preload(4'd0, 32'h3355_AACC);
    waitSet = 0;
    access(1'b0, 32'h2200_0008, 2'd2, 32'd0, rd, err, cyc);
    check("R3 example read", rd, 32'd1);
    check("R2 example target", rdAddr, 32'h2000_0000);
    check("R6 read cycles w0", 32'(cyc), 32'd2);
    check("R5 no lock on alias read", {31'd0, rdLock}, 32'd0);
    access(1'b1, 32'h2200_0008, 2'd2, 32'hFFFF_FFFE, rd, err, cyc);
    check("R4 example write", mem[0], 32'h3355_AAC8);
    check("R5 lock read phase", {31'd0, rdLock}, 32'd1);
    check("R5 lock write phase", {31'd0, wrLock}, 32'd1);
    check("R6 write cycles w0", 32'(cyc), 32'd3);
    shadow[0] = 32'h3355_AAC8;

    // read sweep over both windows, 8 words, all bits, varying waits
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 8; w++)
        for (int b = 0; b < 32; b++) begin
          waitSet = (b + w) % 3;
          access(1'b0, aliasAddr(r, w, b), 2'd2, 32'd0, rd, err, cyc);
          check("R3 sweep read", rd, {31'd0, shadow[{r[0], w[2:0]}][b]});
          check("R6 sweep read cycles", 32'(cyc), 32'(2 + waitSet));
          check("R2 sweep target", rdAddr, regionAddr(r, w));
        end

    // write sweep: toggle each bit with upper data bits set as noise
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 8; w += 3)
        for (int b = 0; b < 32; b++) begin
          logic nb;
          waitSet = b % 3;
          nb = ~shadow[{r[0], w[2:0]}][b];
          access(1'b1, aliasAddr(r, w, b), 2'd2, {31'h2AAA_5555, nb}, rd, err, cyc);
          expWord = shadow[{r[0], w[2:0]}];
          expWord[b] = nb;
          shadow[{r[0], w[2:0]}] = expWord;
          check("R4 sweep word", mem[{r[0], w[2:0]}], expWord);
          check("R2 sweep write target", wrAddr, regionAddr(r, w));
          check("R6 sweep write cycles", 32'(cyc), 32'(3 + 2 * waitSet));
          check("R5 sweep lock", {30'd0, rdLock, wrLock}, 32'd3);
        end

    // last alias words of each window
    waitSet = 1;
    access(1'b0, 32'h23FF_FFFC, 2'd2, 32'd0, rd, err, cyc);
    check("R2 top of window 0", rdAddr, 32'h200F_FFFC);
    check("R3 top bit window 0", rd, {31'd0, shadow[4'd7][31]});
    access(1'b0, 32'h43FF_FFFC, 2'd2, 32'd0, rd, err, cyc);
    check("R2 top of window 1", rdAddr, 32'h400F_FFFC);
    check("R3 top bit window 1", rd, {31'd0, shadow[4'd15][31]});

    // misaligned alias accesses
    for (int m = 1; m < 4; m++) begin
      tx0 = txCount;
      access(1'b1, 32'h2200_0008 + 32'(m), 2'd2, 32'd1, rd, err, cyc);
      check("R7 error flag", {31'd0, err}, 32'd1);
      check("R7 one cycle", 32'(cyc), 32'd1);
      check("R7 no downstream", 32'(txCount - tx0), 32'd0);
      check("R7 memory unchanged", mem[0], shadow[0]);
    end

    // byte and halfword alias accesses act as word accesses
    waitSet = 0;
    access(1'b1, 32'h4200_0010, 2'd0, 32'd1, rd, err, cyc);
    expWord = shadow[4'd8]; expWord[4] = 1'b1; shadow[4'd8] = expWord;
    check("R8 byte write word", mem[8], expWord);
    check("R8 byte read phase size", {30'd0, rdSize}, 32'd2);
    check("R8 byte write phase size", {30'd0, wrSize}, 32'd2);
    access(1'b0, 32'h4200_0010, 2'd1, 32'd0, rd, err, cyc);
    check("R8 halfword read", rd, 32'd1);
    check("R8 halfword size", {30'd0, rdSize}, 32'd2);

    // pass-through and window boundaries
    waitSet = 0;
    access(1'b0, 32'h2000_0008, 2'd1, 32'd0, rd, err, cyc);
    check("R9 pass read data", rd, shadow[4'd2]);
    check("R9 pass address", rdAddr, 32'h2000_0008);
    check("R9 pass size", {30'd0, rdSize}, 32'd1);
    check("R9 zero latency", 32'(cyc), 32'd1);
    check("R9 pass no error", {31'd0, err}, 32'd0);
    waitSet = 2;
    access(1'b1, 32'h6000_0004, 2'd0, 32'hDEAD_BEEF, rd, err, cyc);
    shadow[memIdx(32'h6000_0004)] = 32'hDEAD_BEEF;
    check("R9 pass write addr", wrAddr, 32'h6000_0004);
    check("R9 pass write data", wrData, 32'hDEAD_BEEF);
    check("R9 pass write size", {30'd0, wrSize}, 32'd0);
    check("R5 pass no lock", {31'd0, wrLock}, 32'd0);
    check("R9 pass write cycles", 32'(cyc), 32'd3);
    waitSet = 0;
    access(1'b0, 32'h21FF_FFFC, 2'd2, 32'd0, rd, err, cyc);
    check("R1 below window 0", rdAddr, 32'h21FF_FFFC);
    check("R1 below window 0 data", rd, shadow[memIdx(32'h21FF_FFFC)]);
    access(1'b0, 32'h2400_0000, 2'd2, 32'd0, rd, err, cyc);
    check("R1 above window 0", rdAddr, 32'h2400_0000);
    access(1'b0, 32'h41FF_FFFC, 2'd2, 32'd0, rd, err, cyc);
    check("R1 below window 1", rdAddr, 32'h41FF_FFFC);
    access(1'b0, 32'h4200_0000, 2'd2, 32'd0, rd, err, cyc);
    check("R1 start of window 1", rdAddr, 32'h4000_0000);
    check("R1 start of window 1 cycles", 32'(cyc), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule